// File: doc/BRIEF.md
# Two-Input Quadrature Edge Counter

This block counts edges seen on two asynchronous input pins. In counter mode, only the first input matters: every active edge on it adds one to the count. In encoder mode, both inputs form a quadrature pair. Each qualifying edge steps the count up or down, and the direction depends on the level of the opposite input at that moment. Selecting both edges gives four counts for each full encoder cycle.

The count stays between 0 and a programmable ceiling and wraps at either end. Both pins pass through a multi-flop synchronizer before edge detection, so they may be driven from any clock domain. Software-facing logic sits outside the block. It holds enable high, pulses start once, and reads the count. Dropping enable clears the count and stops counting.

Top module: `quad_edge_counter`

## Requirements
- R1: While enable is low, count is 0 one clock edge later and stays 0.
- R2: After enable rises, the count stays unchanged until a start pulse is sampled with enable high. A new start is needed after every period with enable low.
- R3: In counter mode (enc_mode=0), each active edge on in_a adds 1 to the count. Activity on in_b has no effect.
- R4: edge_sel encodes the active edges: 2'b00 is rising, 2'b01 is falling, and 2'b10 or 2'b11 is both. Non-selected edges never step the count.
- R5: Encoder mode with rising edges: a rising edge on in_a counts down if in_b is high and up if in_b is low. A rising edge on in_b counts up if in_a is high and down if in_a is low.
- R6: Encoder mode with falling edges: a falling edge on in_a counts up if in_b is high and down if in_b is low. A falling edge on in_b counts down if in_a is high and up if in_a is low.
- R7: Stepping up from a count at or above the ceiling gives 0.
- R8: Stepping down from 0 gives the ceiling.
- R9: In encoder mode, if both synchronized inputs change in the same cycle, the count is left unchanged.
- R10: An input change that is set up before clock edge k shows on count at edge k+2 and not earlier. This holds with the default of two synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Counter enable; low clears the count |
| start | input | 1 | Start strobe, arms counting while enabled |
| enc_mode | input | 1 | 0: up-counter on in_a, 1: quadrature decoder |
| edge_sel | input | 2 | Active edge polarity (see R4) |
| ceiling | input | CNT_W | Wrap value of the count |
| in_a | input | 1 | First counting input, asynchronous |
| in_b | input | 1 | Second counting input, asynchronous |
| count | output | CNT_W | Current count |

## Verification
On every cycle, the checker confirms the following. The count is cleared while disabled. The count never moves before it is armed. Each update is a single step or a wrap to 0 or to the ceiling. Activity on the second input leaves the count alone in counter mode. A simultaneous change of both inputs never moves the count in encoder mode. Only the bench scenarios can show the following: the direction table for each polarity, the exact three-edge latency, and the wrap values at a small ceiling. These scenarios cover both directed sequences and seeded random toggling, checked against a reference model.

// File: rtl/qec_pkg.sv
package qec_pkg;
   typedef enum logic [1:0] {
      POL_RISE = 2'b00,
      POL_FALL = 2'b01,
      POL_BOTH = 2'b10,
      POL_BTH2 = 2'b11
   } pol_e;

   function automatic logic pol_has_rise(input logic [1:0] sel);
      return (sel != POL_FALL);
   endfunction

   function automatic logic pol_has_fall(input logic [1:0] sel);
      return (sel != POL_RISE);
   endfunction
endpackage

// File: rtl/qec_sync.sv
module qec_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("qec_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
   end
endmodule

// File: rtl/qec_edge_dir.sv
module qec_edge_dir
   import qec_pkg::*;
#(
   parameter bit HAS_ENC = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cur,
   input  logic       enc_mode,
   input  logic [1:0] edge_sel,
   output logic [1:0] prev,
   output logic       step_up,
   output logic       step_dn
);
   logic a, b, pa, pb;
   logic ra, fa, rb, fb, use_r, use_f;
   logic cnt_up;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= cur;
   end

   assign a  = cur[0];
   assign b  = cur[1];
   assign pa = prev[0];
   assign pb = prev[1];
   assign ra = a & ~pa;
   assign fa = ~a & pa;
   assign rb = b & ~pb;
   assign fb = ~b & pb;
   assign use_r = pol_has_rise(edge_sel);
   assign use_f = pol_has_fall(edge_sel);

   assign cnt_up = (use_r & ra) | (use_f & fa);

   if (HAS_ENC) begin : g_enc
      logic invalid, e_up, e_dn;
      assign invalid = (a ^ pa) & (b ^ pb);
      assign e_up = (use_r & ra & ~b) | (use_r & rb & a) |
                    (use_f & fa & b)  | (use_f & fb & ~a);
      assign e_dn = (use_r & ra & b)  | (use_r & rb & ~a) |
                    (use_f & fa & ~b) | (use_f & fb & a);
      always_comb begin
         if (enc_mode) begin
            step_up = e_up & ~invalid;
            step_dn = e_dn & ~invalid;
         end else begin
            step_up = cnt_up;
            step_dn = 1'b0;
         end
      end
   end else begin : g_cnt_only
      logic unused_mode;
      assign unused_mode = enc_mode;
      assign step_up = cnt_up;
      assign step_dn = 1'b0;
   end
endmodule

// File: rtl/qec_count.sv
module qec_count #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start,
   input  logic             step_up,
   input  logic             step_dn,
   input  logic [CNT_W-1:0] ceiling,
   output logic             run_q,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         count <= '0;
      end else if (!enable) begin
         run_q <= 1'b0;
         count <= '0;
      end else begin
         if (start) run_q <= 1'b1;
         if (run_q && step_up) begin
            count <= (count >= ceiling) ? '0 : count + ONE;
         end else if (run_q && step_dn) begin
            count <= (count == '0) ? ceiling : count - ONE;
         end
      end
   end
endmodule

// File: rtl/quad_edge_counter.sv
module quad_edge_counter
   import qec_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_ENC     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             start,
   input  logic             enc_mode,
   input  logic [1:0]       edge_sel,
   input  logic [CNT_W-1:0] ceiling,
   input  logic             in_a,
   input  logic             in_b,
   output logic [CNT_W-1:0] count
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
      $error("quad_edge_counter: CNT_W must lie in 2..32");
   end

   logic [1:0] sync_ab;
   logic [1:0] prev_ab;
   logic       step_up, step_dn, run_q;

   qec_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .d({in_b, in_a}), .q(sync_ab)
   );

   qec_edge_dir #(.HAS_ENC(HAS_ENC)) dir_i (
      .clk(clk), .rst_n(rst_n), .cur(sync_ab), .enc_mode(enc_mode),
      .edge_sel(edge_sel), .prev(prev_ab),
      .step_up(step_up), .step_dn(step_dn)
   );

   qec_count #(.CNT_W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
      .step_up(step_up), .step_dn(step_dn), .ceiling(ceiling),
      .run_q(run_q), .count(count)
   );
endmodule

// File: rtl/qec_checker.sv
module qec_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             enc_mode,
   input logic [CNT_W-1:0] ceiling,
   input logic [CNT_W-1:0] count,
   input logic [1:0]       sync_ab,
   input logic [1:0]       prev_ab,
   input logic             run_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> count == '0);

   assert_not_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !run_q) |=> (!enable || $stable(count)));

   assert_b_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !enc_mode && sync_ab[0] == prev_ab[0]) |=> (!enable || $stable(count)));

   assert_step_or_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      enable |=> (!enable || count == $past(count) || count == $past(count) + ONE ||
                  count == $past(count) - ONE || count == '0 || count == $past(ceiling)));

   assert_down_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && count == '0) |=> (!enable || count == '0 || count == ONE || count == $past(ceiling)));

   assert_dual_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && enc_mode && sync_ab[0] != prev_ab[0] && sync_ab[1] != prev_ab[1])
      |=> (!enable || $stable(count)));
endmodule

bind quad_edge_counter qec_checker #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .enable(enable), .enc_mode(enc_mode),
   .ceiling(ceiling), .count(count), .sync_ab(sync_ab), .prev_ab(prev_ab),
   .run_q(run_q)
);

// File: tb/quad_edge_counter_tb_top.sv
module quad_edge_counter_tb_top;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0, start = 1'b0, enc_mode = 1'b0;
   logic [1:0]   edge_sel = 2'b00;
   logic [W-1:0] ceiling = 16'hFFFF;
   logic         in_a = 1'b0, in_b = 1'b0;
   logic [W-1:0] count;

   int checks = 0, errors = 0;
   logic [W-1:0] exp_cnt = '0;
   bit exp_run = 1'b0;

   always #10 clk = ~clk;

   quad_edge_counter #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
      .enc_mode(enc_mode), .edge_sel(edge_sel), .ceiling(ceiling),
      .in_a(in_a), .in_b(in_b), .count(count)
   );

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: count=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [W-1:0] model(logic [W-1:0] c, logic [W-1:0] ceil,
         bit run, bit enc, logic [1:0] sel, bit oa, bit ob, bit na, bit nb);
      bit r = (sel != 2'b01), f = (sel != 2'b00);
      int dir = 0;
      if (!run) return c;
      if (!enc) begin
         if ((r && !oa && na) || (f && oa && !na)) dir = 1;
      end else if ((oa != na) && (ob != nb)) begin
         dir = 0;
      end else if (oa != na) begin
         if (na && r)  dir = nb ? -1 : 1;
         if (!na && f) dir = nb ? 1 : -1;
      end else if (ob != nb) begin
         if (nb && r)  dir = na ? 1 : -1;
         if (!nb && f) dir = na ? -1 : 1;
      end
      if (dir == 1)  return (c >= ceil) ? '0 : c + 1'b1;
      if (dir == -1) return (c == '0) ? ceil : c - 1'b1;
      return c;
   endfunction

   task automatic apply(bit na, bit nb, string req);
      @(negedge clk);
      exp_cnt = model(exp_cnt, ceiling, exp_run, enc_mode, edge_sel, in_a, in_b, na, nb);
      in_a = na; in_b = nb;
      repeat (3) @(negedge clk);
      chk(req, count, exp_cnt);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      exp_run = enable;
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: count=%0d expected=%0d", count, exp_cnt);
      summary();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      chk("R1 reset", count, '0);
      rst_n = 1'b1;
      @(negedge clk); enable = 1'b1;
      // R2: edges before start do nothing
      apply(1, 0, "R2 unarmed"); apply(0, 0, "R2 unarmed");
      pulse_start();
      // R3/R4 counter mode, rising
      apply(1, 0, "R3 rise"); apply(0, 0, "R4 fall ignored");
      apply(0, 1, "R3 in_b ignored"); apply(0, 0, "R3 in_b ignored");
      chk("R3 total", count, 16'd1);
      // R10 latency
      @(negedge clk); in_a = 1'b1; exp_cnt = exp_cnt + 1'b1;
      @(negedge clk); chk("R10 early k", count, exp_cnt - 1'b1);
      @(negedge clk); chk("R10 early k+1", count, exp_cnt - 1'b1);
      @(negedge clk); chk("R10 at k+2", count, exp_cnt);
      edge_sel = 2'b01;
      apply(0, 0, "R4 falling"); apply(1, 0, "R4 rise ignored");
      edge_sel = 2'b10;
      apply(0, 0, "R4 both"); apply(1, 0, "R4 both");
      apply(0, 0, "R4 both");
      // encoder mode
      enc_mode = 1'b1; edge_sel = 2'b00;
      apply(0, 0, "R5 idle");
      apply(1, 0, "R5 A rise B low up");
      apply(1, 1, "R5 B rise A high up");
      apply(0, 1, "R5 A fall ignored");
      apply(1, 1, "R5 A rise B high down");
      apply(1, 0, "R5 B fall ignored"); apply(0, 0, "R5 A fall ignored");
      apply(0, 1, "R5 B rise A low down");
      edge_sel = 2'b01;
      apply(1, 1, "R6 A rise ignored");
      apply(0, 1, "R6 A fall B high up");
      apply(0, 0, "R6 B fall A low up");
      apply(1, 0, "R6 rise ignored");
      apply(1, 1, "R6 rise ignored");
      apply(1, 0, "R6 B fall A high down");
      apply(0, 0, "R6 A fall B low down");
      edge_sel = 2'b11;
      for (int i = 0; i < 2; i++) begin
         apply(1, 0, "R6 x4"); apply(1, 1, "R6 x4");
         apply(0, 1, "R6 x4"); apply(0, 0, "R6 x4");
      end
      // wraps at small ceiling
      @(negedge clk); enable = 1'b0; exp_run = 1'b0; exp_cnt = '0;
      @(negedge clk); chk("R1 disable clears", count, '0);
      ceiling = 16'd3; enable = 1'b1;
      @(negedge clk);
      apply(1, 0, "R2 needs new start"); apply(1, 1, "R2 needs new start");
      pulse_start();
      apply(1, 0, "R8 down from 0"); chk("R8 wrap value", count, 16'd3);
      apply(1, 1, "R7 up from ceiling"); chk("R7 wrap value", count, 16'd0);
      // R9 simultaneous change
      apply(0, 0, "R9 both change"); chk("R9 held", count, 16'd0);
      apply(1, 1, "R9 both change");
      // random mix
      ceiling = 16'd9;
      for (int i = 0; i < 400; i++) begin
         int r;
         if (i % 50 == 0) begin
            @(negedge clk);
            enc_mode = ($urandom % 4) != 0;
            edge_sel = 2'($urandom % 4);
         end
         r = $urandom % 16;
         if (r == 0)     apply(!in_a, !in_b, "R9 random");
         else if (r < 9) apply(!in_a, in_b, enc_mode ? "R5/R6 random A" : "R3 random A");
         else            apply(in_a, !in_b, enc_mode ? "R5/R6 random B" : "R3 random B");
      end
      @(negedge clk); enable = 1'b0; exp_cnt = '0; exp_run = 1'b0;
      @(negedge clk); chk("R1 final clear", count, '0);
      summary();
   end
endmodule